// File: doc/BRIEF.md
# Vertical-Blanking Copy-Control Word Inserter

This block sits in the digital video path after the timing generator. It overlays a 14-bit copy-management word onto the luma stream during one chosen vertical-blanking line of a 525-line progressive frame. The timing generator supplies the current line and sample numbers. Software supplies an enable bit, a 6-bit header and an 8-bit payload. The block plays those bits out unchanged. It applies no coding and computes no check bits.

On the target line, when the block is enabled and the progressive format is selected, each word bit takes a fixed run of samples. A bit at one is driven at 70% of the full 10-bit code range. A bit at zero is driven at the luma blanking code. Both chroma channels are held at their blanking code for the whole line. On every other line, and whenever insertion is disabled, the three sample streams pass through unchanged. Every output is registered and lags its input by one clock.

The word is captured from the header and payload inputs on every sample that lies off the target line. It is frozen for the whole target line, so software writes made during that line cannot tear the word.

Top module: `vbi_cm_inserter`

## Requirements
- R1: When insertion is inactive, y_out, pb_out and pr_out equal the y_in, pb_in and pr_in values of the previous clock.
- R2: With ins_en low, the target line passes through unchanged as in R1.
- R3: Insertion happens only when fmt_525p is high and line_num equals 41. With fmt_525p low, or on any other line, the streams pass through unchanged.
- R4: While insertion is active, pb_out and pr_out are 512, the chroma blanking code for 10-bit samples.
- R5: The word is {header, payload}. It is sent header MSB first, then payload MSB first. Word bit k (k=0 is the header MSB) occupies samples start_ofs+8k through start_ofs+8k+7.
- R6: During an active bit cell, y_out is 716 (70% of 1023) for a one and 64 for a zero. The y_in value has no effect.
- R7: On an active line, any sample before start_ofs or at or after start_ofs+112 gives y_out = 64.
- R8: The word played on line 41 is the header and payload value present on the last sample before line 41. Changes to hdr or pay during line 41 have no effect on that line.
- R9: While rst_n is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insertion enable |
| fmt_525p | input | 1 | High when the 525-line progressive format is selected |
| hdr | input | 6 | Header field of the copy-control word |
| pay | input | 8 | Payload field of the copy-control word |
| start_ofs | input | 11 | Sample number where the first bit cell begins |
| line_num | input | 11 | Current line number from the timing generator |
| sample_num | input | 11 | Current sample number within the line |
| y_in | input | 10 | Incoming luma sample |
| pb_in | input | 10 | Incoming blue-difference sample |
| pr_in | input | 10 | Incoming red-difference sample |
| y_out | output | 10 | Luma sample with the word overlaid |
| pb_out | output | 10 | Blue-difference sample, at blank while inserting |
| pr_out | output | 10 | Red-difference sample, at blank while inserting |

## Verification
If the frozen word register loads when it should not, the fault first shows on the target line. The bit cells after the write point carry the new value, and the mismatch appears within eight samples of the first cell that differs. If the cell decoder computes a wrong index, the luma output shows a shifted or reversed bit pattern, or a one-code outside the 112-sample window, from the first cell on. If the format or line gating is wrong, whole lines fail: either active video is replaced by blank and word codes, or the word is missing. Each of these faults is visible one clock after the sample that causes it.

// File: rtl/vbi_cm_pkg.sv
package vbi_cm_pkg;

   // Code equal to pct percent of the full-scale code of a w-bit sample.
   function automatic int unsigned pct_of_full(input int unsigned w, input int unsigned pct);
      return (((1 << w) - 1) * pct) / 100;
   endfunction

   // Luma blanking code scaled from its 8-bit value of 16.
   function automatic int unsigned luma_blank(input int unsigned w);
      return 16 << (w - 8);
   endfunction

   // Chroma blanking code: mid-scale.
   function automatic int unsigned chroma_blank(input int unsigned w);
      return 1 << (w - 1);
   endfunction

endpackage

// File: rtl/vbi_cm_word_latch.sv
module vbi_cm_word_latch #(
   parameter int HDR_W  = 6,
   parameter int PAY_W  = 8,
   localparam int WORD_W = HDR_W + PAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [HDR_W-1:0]  hdr,
   input  logic [PAY_W-1:0]  pay,
   output logic [WORD_W-1:0] word
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         word <= '0;
      else if (!hold)
         word <= {hdr, pay};
   end

   // The word must not move across consecutive held samples.
   assert_word_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold) |-> $stable(word));

endmodule

// File: rtl/vbi_cm_cell_sel.sv
module vbi_cm_cell_sel #(
   parameter int SAMPLE_W = 11,
   parameter int WORD_W   = 14,
   parameter int CELL     = 8,
   localparam int SPAN    = WORD_W * CELL,
   localparam int IDX_W   = $clog2(WORD_W)
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] ofs,
   input  logic [WORD_W-1:0]   word,
   output logic                in_window,
   output logic                bit_val
);

   logic [SAMPLE_W:0] rel;
   logic [SAMPLE_W:0] idx_full;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  pos;

   generate
      if (SPAN >= (1 << SAMPLE_W)) begin : g_bad_span
         $error("bit-cell span does not fit the sample counter");
      end
      if ((CELL & (CELL - 1)) == 0) begin : g_shift
         always_comb idx_full = rel >> $clog2(CELL);
      end else begin : g_div
         always_comb idx_full = rel / (SAMPLE_W+1)'(CELL);
      end
   endgenerate

   always_comb begin
      rel       = {1'b0, sample} - {1'b0, ofs};
      in_window = (sample >= ofs) && (rel < (SAMPLE_W+1)'(SPAN));
      idx       = idx_full[IDX_W-1:0];
      pos       = IDX_W'(WORD_W - 1) - idx;
      bit_val   = in_window && word[pos];
   end

endmodule

// File: rtl/vbi_cm_inserter.sv
module vbi_cm_inserter #(
   parameter int DATA_W       = 10,
   parameter int LINE_W       = 11,
   parameter int SAMPLE_W     = 11,
   parameter int HDR_W        = 6,
   parameter int PAY_W        = 8,
   parameter int TARGET_LINE  = 41,
   parameter int CELL_SAMPLES = 8,
   parameter int ONE_PCT      = 70,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ins_en,
   input  logic                fmt_525p,
   input  logic [HDR_W-1:0]    hdr,
   input  logic [PAY_W-1:0]    pay,
   input  logic [SAMPLE_W-1:0] start_ofs,
   input  logic [LINE_W-1:0]   line_num,
   input  logic [SAMPLE_W-1:0] sample_num,
   input  logic [DATA_W-1:0]   y_in,
   input  logic [DATA_W-1:0]   pb_in,
   input  logic [DATA_W-1:0]   pr_in,
   output logic [DATA_W-1:0]   y_out,
   output logic [DATA_W-1:0]   pb_out,
   output logic [DATA_W-1:0]   pr_out
);
   import vbi_cm_pkg::*;

   localparam int WORD_W = HDR_W + PAY_W;
   localparam logic [DATA_W-1:0] ONE_CODE = DATA_W'(pct_of_full(DATA_W, ONE_PCT));
   localparam logic [DATA_W-1:0] Y_BLANK  = DATA_W'(luma_blank(DATA_W));
   localparam logic [DATA_W-1:0] C_BLANK  = DATA_W'(chroma_blank(DATA_W));

   generate
      if (DATA_W < 8) begin : g_bad_w
         $error("DATA_W must be at least 8");
      end
      if (TARGET_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("target line does not fit the line counter");
      end
      if (ONE_PCT < 1 || ONE_PCT > 100) begin : g_bad_pct
         $error("ONE_PCT out of range");
      end
   endgenerate

   logic              on_line;
   logic              active;
   logic [WORD_W-1:0] word;
   logic              in_cell;
   logic              cell_bit;
   logic [DATA_W-1:0] y_n, pb_n, pr_n;

   assign on_line = (line_num == LINE_W'(TARGET_LINE));
   assign active  = ins_en && fmt_525p && on_line;

   vbi_cm_word_latch #(.HDR_W(HDR_W), .PAY_W(PAY_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (on_line),
      .hdr   (hdr),
      .pay   (pay),
      .word  (word)
   );

   vbi_cm_cell_sel #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .CELL(CELL_SAMPLES)) u_cell (
      .sample    (sample_num),
      .ofs       (start_ofs),
      .word      (word),
      .in_window (in_cell),
      .bit_val   (cell_bit)
   );

   always_comb begin
      if (active) begin
         y_n  = (in_cell && cell_bit) ? ONE_CODE : Y_BLANK;
         pb_n = C_BLANK;
         pr_n = C_BLANK;
      end else begin
         y_n  = y_in;
         pb_n = pb_in;
         pr_n = pr_in;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         logic primed;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               y_out  <= '0;
               pb_out <= '0;
               pr_out <= '0;
               primed <= 1'b0;
            end else begin
               y_out  <= y_n;
               pb_out <= pb_n;
               pr_out <= pr_n;
               primed <= 1'b1;
            end
         end

         assert_chroma_blank_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            $past(active) |-> (pb_out == C_BLANK && pr_out == C_BLANK));

         assert_luma_code_R6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            $past(active) |-> (y_out == Y_BLANK || y_out == ONE_CODE));

         assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            !$past(active) |-> (y_out == $past(y_in) && pb_out == $past(pb_in) && pr_out == $past(pr_in)));
      end else begin : g_comb
         assign y_out  = y_n;
         assign pb_out = pb_n;
         assign pr_out = pr_n;
      end
   endgenerate

endmodule

// File: tb/tb_vbi_cm_inserter.sv
module tb_vbi_cm_inserter;
   localparam int LEN  = 200;
   localparam int CELL = 8;
   localparam int SPAN = 14 * CELL;
   localparam logic [9:0] ONE = 10'd716, YB = 10'd64, CB = 10'd512;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ins_en = 0, fmt_525p = 0;
   logic [5:0] hdr = 0;
   logic [7:0] pay = 0;
   logic [10:0] start_ofs = 0, line_num = 0, sample_num = 0;
   logic [9:0] y_in = 0, pb_in = 0, pr_in = 0;
   logic [9:0] y_out, pb_out, pr_out;

   int n_chk = 0, n_bad = 0;
   logic [13:0] model_word = '0;

   always #5 clk = ~clk;

   vbi_cm_inserter dut (
      .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .fmt_525p(fmt_525p),
      .hdr(hdr), .pay(pay), .start_ofs(start_ofs), .line_num(line_num),
      .sample_num(sample_num), .y_in(y_in), .pb_in(pb_in), .pr_in(pr_in),
      .y_out(y_out), .pb_out(pb_out), .pr_out(pr_out)
   );

   task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s line=%0d sample=%0d got=%0d expected=%0d", tag, line_num, sample_num, got, exp);
      end
   endtask

   function automatic logic [9:0] exp_y(input logic act, input int s, input int ofs,
                                         input logic [13:0] w, input logic [9:0] yi);
      if (!act) return yi;
      if (s < ofs || s >= ofs + SPAN) return YB;
      return w[13 - (s - ofs) / CELL] ? ONE : YB;
   endfunction

   // One sample: drive, clock, compare.
   task automatic one_sample(input string tag, input int ln, input int s);
      logic act;
      logic [9:0] ey, epb, epr;
      @(negedge clk);
      line_num   = 11'(ln);
      sample_num = 11'(s);
      y_in  = 10'($urandom_range(0, 1023));
      pb_in = 10'($urandom_range(0, 1023));
      pr_in = 10'($urandom_range(0, 1023));
      act = ins_en && fmt_525p && (ln == 41);
      ey  = exp_y(act, s, int'(start_ofs), model_word, y_in);
      epb = act ? CB : pb_in;
      epr = act ? CB : pr_in;
      if (ln != 41) model_word = {hdr, pay};
      @(posedge clk);
      #1;
      chk(act ? ((s < int'(start_ofs) || s >= int'(start_ofs) + SPAN) ? "R7" : "R5/R6") : tag, y_out, ey);
      chk(act ? "R4" : tag, pb_out, epb);
      chk(act ? "R4" : tag, pr_out, epr);
   endtask

   // A whole line preceded by one sample of line 40.
   task automatic run_line(input string tag, input int ln, input logic en, input logic fmt,
                           input int ofs, input logic [5:0] h, input logic [7:0] p,
                           input int change_at);
      @(negedge clk);
      ins_en = en; fmt_525p = fmt; start_ofs = 11'(ofs); hdr = h; pay = p;
      one_sample("R1", 40, LEN - 1);
      for (int s = 0; s < LEN; s++) begin
         if (s == change_at) begin
            hdr = ~h; pay = ~p;  // R8: write during the line
         end
         one_sample(tag, ln, s);
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      chk("R9", y_out, 10'd0);
      chk("R9", pb_out, 10'd0);
      chk("R9", pr_out, 10'd0);
      @(negedge clk);
      rst_n = 1'b1;

      run_line("R1", 40, 1, 1, 20, 6'h2A, 8'hC3, -1);
      run_line("R5", 41, 1, 1, 20, 6'h2A, 8'hC3, -1);
      run_line("R6", 41, 1, 1, 0, 6'h3F, 8'hFF, -1);
      run_line("R7", 41, 1, 1, LEN - SPAN, 6'h00, 8'h00, -1);
      run_line("R5", 41, 1, 1, LEN - SPAN, 6'h01, 8'h80, -1);
      run_line("R2", 41, 0, 1, 10, 6'h3F, 8'hFF, -1);
      run_line("R3", 41, 1, 0, 10, 6'h3F, 8'hFF, -1);
      run_line("R3", 42, 1, 1, 10, 6'h3F, 8'hFF, -1);
      run_line("R8", 41, 1, 1, 30, 6'h15, 8'h5A, 45);
      run_line("R8", 41, 1, 1, 5, 6'h33, 8'h0F, 0);
      for (int i = 0; i < 14; i++) begin
         int ln;
         ln = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 600)) : 41;
         run_line("R1", ln, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
                  int'($urandom_range(0, LEN - SPAN)), 6'($urandom), 8'($urandom),
                  ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, LEN - 1)) : -1);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule